// File: doc/BRIEF.md
# Self-Checking Iterative Block Cipher Wrapper

This block encrypts or decrypts 32-bit words with a small iterative cipher of eight one-cycle rounds. It has an encryption datapath and a decryption datapath, and both read one shared table of sixteen round-key words. Software fills that table through a write port before it sends any data.

To guard against induced faults, the wrapper can check a block after its primary pass. It runs the result back through the opposite datapath and compares the outcome with a copy of the original input, which it saved when the block was accepted. If the two match, the result is offered on a ready/valid output. If they differ, the result is thrown away and a sticky error flag goes up.

The two passes use the same key table, so the wrapper takes only one block at a time. A checked block costs twice the plain pass time. A programmable period lets most blocks skip the check, and those blocks come out after a single pass.

Top module: `cipher_check_wrap`

## Requirements
- R1: After reset, inReady is 1, busy is 0, outValid is 0 and errFlag is 0.
- R2: keyWe writes keyData into word keyAddr (4 bits, 16 words). Round i (0..7) adds word 2i and XORs word 2i+1.
- R3: With inDecrypt=0, the result is eight rounds applied for i = 0 up to 7. Each round is x = rotl(x + key[2i], 5) ^ key[2i+1], where rotl rotates a 32-bit word left.
- R4: With inDecrypt=1, the result is rounds applied for i = 7 down to 0. Each round is x = rotr(x ^ key[2i+1], 5) - key[2i], so decrypting a ciphertext returns its plaintext.
- R5: A block is accepted on a clock edge where inValid and inReady are both 1. inReady is 1 only when the wrapper is idle. busy is 1 from the cycle after acceptance until the result is taken or an error ends the block.
- R6: While outValid is 1 and outReady is 0, outValid stays 1 and outData does not change.
- R7: outValid first appears 8 cycles after the accepting edge for an unchecked block, and 16 cycles after it for a checked block.
- R8: A checked block's result is passed through the opposite direction in reverse round order and compared with the saved input. On a mismatch, errFlag is set, no outValid is given, and the wrapper returns to idle.
- R9: A modulo counter counts accepted blocks from reset. A block is checked when the counter is 0. The counter wraps to 0 when its incremented value reaches max(checkPeriod, 1), with checkPeriod sampled at acceptance.
- R10: errFlag stays 1 until errClear is 1 on a clock edge. A new mismatch on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyWe | input | 1 | Round-key write enable |
| keyAddr | input | 4 | Round-key word index |
| keyData | input | 32 | Round-key word value |
| checkPeriod | input | 4 | One block in this many is checked (0 acts as 1) |
| inValid | input | 1 | Input block offered |
| inReady | output | 1 | Wrapper idle, can accept |
| inDecrypt | input | 1 | 1 selects decryption as the primary pass |
| inData | input | 32 | Input block |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 32 | Result block |
| busy | output | 1 | Block in progress |
| errFlag | output | 1 | Sticky check-mismatch flag |
| errClear | input | 1 | Clears errFlag |

## Verification
The assertions assume that the consumer may hold outReady low for any number of cycles. They also assume that inValid is asserted only between blocks, so an acceptance always starts from idle. The bench meets both assumptions by offering a block only after it sees inReady, and by stalling outReady only while a result is pending. To force a mismatch, the bench rewrites a round-key word while the check pass is running. This is the only legal way to make the inverse pass disagree. It changes a key that the forward pass has already finished using, so the expected result stays well defined.

// File: rtl/cipher_check_pkg.sv
package cipher_check_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FWD, ST_CHK, ST_OUT} phase_t;

  typedef struct packed {
    logic capture;   // latch input into work and hold registers
    logic fwdStep;   // one round of the primary pass
    logic chkStep;   // one round of the inverse check pass
    logic latchRes;  // store primary result
    logic useDec;    // primary pass direction is decryption
  } ctl_t;
endpackage

// File: rtl/cipher_keystore.sv
module cipher_keystore #(
  parameter int WIDTH = 32,
  parameter int WORDS = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddrA,
  input  logic [AW-1:0]    rAddrB,
  output logic [WIDTH-1:0] rDataA,
  output logic [WIDTH-1:0] rDataB
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wAddr] <= wData;
    end
  end

  assign rDataA = mem[rAddrA];
  assign rDataB = mem[rAddrB];
endmodule

// File: rtl/cipher_datapath.sv
module cipher_datapath
  import cipher_check_pkg::*;
#(
  parameter int BLOCK_W = 32,
  parameter int ROUNDS  = 8,
  parameter int ROT     = 5,
  localparam int KEY_WORDS = 2 * ROUNDS,
  localparam int KEY_AW    = $clog2(KEY_WORDS),
  localparam int RND_W     = $clog2(ROUNDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [RND_W-1:0]   rnd,
  input  logic               keyWe,
  input  logic [KEY_AW-1:0]  keyAddr,
  input  logic [BLOCK_W-1:0] keyData,
  input  logic [BLOCK_W-1:0] inData,
  output logic [BLOCK_W-1:0] outData,
  output logic               match
);
  logic [BLOCK_W-1:0] workReg, holdReg, resReg;
  logic [BLOCK_W-1:0] addKey, xorKey;
  logic [BLOCK_W-1:0] encSum, encOut, decMix, decOut, stepOut;
  logic               stepDec;

  cipher_keystore #(.WIDTH(BLOCK_W), .WORDS(KEY_WORDS)) uKeys (
    .clk(clk), .rstN(rstN), .we(keyWe), .wAddr(keyAddr), .wData(keyData),
    .rAddrA({rnd, 1'b0}), .rAddrB({rnd, 1'b1}),
    .rDataA(addKey), .rDataB(xorKey)
  );

  // forward round: add, rotate left, xor
  assign encSum = workReg + addKey;
  assign encOut = ((encSum << ROT) | (encSum >> (BLOCK_W - ROT))) ^ xorKey;
  // inverse round: xor, rotate right, subtract
  assign decMix = workReg ^ xorKey;
  assign decOut = ((decMix >> ROT) | (decMix << (BLOCK_W - ROT))) - addKey;

  assign stepDec = ctl.chkStep ? !ctl.useDec : ctl.useDec;
  assign stepOut = stepDec ? decOut : encOut;
  assign match   = (stepOut == holdReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workReg <= '0;
      holdReg <= '0;
      resReg  <= '0;
    end else begin
      if (ctl.capture) begin
        workReg <= inData;
        holdReg <= inData;
      end else if (ctl.fwdStep || ctl.chkStep) begin
        workReg <= stepOut;
      end
      if (ctl.latchRes) resReg <= stepOut;
    end
  end

  assign outData = resReg;
endmodule

// File: rtl/cipher_control.sv
module cipher_control
  import cipher_check_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int PER_W  = 4,
  localparam int RND_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inDecrypt,
  input  logic [PER_W-1:0] checkPeriod,
  input  logic             outReady,
  input  logic             errClear,
  input  logic             match,
  output ctl_t             ctl,
  output logic [RND_W-1:0] rnd,
  output logic             inReady,
  output logic             outValid,
  output logic             busy,
  output logic             errFlag
);
  localparam logic [RND_W-1:0] LAST = RND_W'(ROUNDS - 1);

  phase_t           phase;
  logic [RND_W-1:0] cnt;
  logic [PER_W-1:0] blkCnt, perEff, blkNext;
  logic             decReg, doChk, accept, lastStep, mismatch;

  assign inReady  = (phase == ST_IDLE);
  assign outValid = (phase == ST_OUT);
  assign busy     = !inReady;
  assign accept   = inValid && inReady;
  assign lastStep = (cnt == LAST);
  assign mismatch = (phase == ST_CHK) && lastStep && !match;
  assign perEff   = (checkPeriod == '0) ? PER_W'(1) : checkPeriod;
  assign blkNext  = ((blkCnt + PER_W'(1)) >= perEff) ? '0 : blkCnt + PER_W'(1);

  always_comb begin
    ctl.capture  = accept;
    ctl.fwdStep  = (phase == ST_FWD);
    ctl.chkStep  = (phase == ST_CHK);
    ctl.latchRes = (phase == ST_FWD) && lastStep;
    ctl.useDec   = decReg;
    // an encrypting pass walks rounds upward, a decrypting pass downward
    if ((phase == ST_FWD) == decReg) rnd = LAST - cnt;
    else                             rnd = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= ST_IDLE;
      cnt     <= '0;
      blkCnt  <= '0;
      decReg  <= 1'b0;
      doChk   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (mismatch)      errFlag <= 1'b1;
      else if (errClear) errFlag <= 1'b0;
      unique case (phase)
        ST_IDLE: if (accept) begin
          decReg <= inDecrypt;
          doChk  <= (blkCnt == '0);
          blkCnt <= blkNext;
          cnt    <= '0;
          phase  <= ST_FWD;
        end
        ST_FWD: begin
          cnt <= lastStep ? '0 : cnt + RND_W'(1);
          if (lastStep) phase <= doChk ? ST_CHK : ST_OUT;
        end
        ST_CHK: begin
          cnt <= lastStep ? '0 : cnt + RND_W'(1);
          if (lastStep) phase <= match ? ST_OUT : ST_IDLE;
        end
        ST_OUT: if (outReady) phase <= ST_IDLE;
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cipher_check_wrap.sv
module cipher_check_wrap
  import cipher_check_pkg::*;
#(
  parameter int BLOCK_W = 32,
  parameter int ROUNDS  = 8,
  parameter int ROT     = 5,
  parameter int PER_W   = 4,
  localparam int KEY_AW = $clog2(2 * ROUNDS),
  localparam int RND_W  = $clog2(ROUNDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               keyWe,
  input  logic [KEY_AW-1:0]  keyAddr,
  input  logic [BLOCK_W-1:0] keyData,
  input  logic [PER_W-1:0]   checkPeriod,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inDecrypt,
  input  logic [BLOCK_W-1:0] inData,
  output logic               outValid,
  input  logic               outReady,
  output logic [BLOCK_W-1:0] outData,
  output logic               busy,
  output logic               errFlag,
  input  logic               errClear
);
  ctl_t             ctl;
  logic [RND_W-1:0] rnd;
  logic             match;

  cipher_control #(.ROUNDS(ROUNDS), .PER_W(PER_W)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDecrypt(inDecrypt),
    .checkPeriod(checkPeriod), .outReady(outReady), .errClear(errClear),
    .match(match), .ctl(ctl), .rnd(rnd), .inReady(inReady),
    .outValid(outValid), .busy(busy), .errFlag(errFlag)
  );

  cipher_datapath #(.BLOCK_W(BLOCK_W), .ROUNDS(ROUNDS), .ROT(ROT)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rnd(rnd), .keyWe(keyWe),
    .keyAddr(keyAddr), .keyData(keyData), .inData(inData),
    .outData(outData), .match(match)
  );
endmodule

// File: rtl/cipher_check_sva.sv
module cipher_check_sva #(
  parameter int BLOCK_W = 32,
  parameter int ROUNDS  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic               outValid,
  input logic               outReady,
  input logic [BLOCK_W-1:0] outData,
  input logic               busy,
  input logic               errFlag,
  input logic               errClear
);
  localparam int CW = $clog2(2 * ROUNDS + 2) + 1;
  localparam logic [CW-1:0] LIM = CW'(2 * ROUNDS + 1);
  logic [CW-1:0] sinceAcc;

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceAcc <= '0;
    else if (inValid && inReady) sinceAcc <= '0;
    else if (sinceAcc != LIM)   sinceAcc <= sinceAcc + CW'(1);
  end

  assert_accept_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> busy && !inReady);

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (sinceAcc == CW'(ROUNDS) || sinceAcc == CW'(2 * ROUNDS)));

  assert_err_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> inReady && !outValid);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClear |=> errFlag);
endmodule

bind cipher_check_wrap cipher_check_sva #(.BLOCK_W(BLOCK_W), .ROUNDS(ROUNDS)) uSva (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData),
  .busy(busy), .errFlag(errFlag), .errClear(errClear)
);

// File: tb/sim_cipher_check_wrap.sv
module sim_cipher_check_wrap;
  logic        clk = 0, rstN = 0;
  logic        keyWe = 0, inValid = 0, inDecrypt = 0, outReady = 1, errClear = 0;
  logic [3:0]  keyAddr = 0, checkPeriod = 1;
  logic [31:0] keyData = 0, inData = 0;
  logic        inReady, outValid, busy, errFlag;
  logic [31:0] outData;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side key table and reference model state
  logic [31:0] kb [16];
  int          mState = 0, mCnt = 0, mLen = 0, mBlk = 0;
  bit          mChk = 0, mErr = 0, mInject = 0;
  logic [31:0] mRes = 0, lastOut = 0;

  always #2 clk = ~clk;

  cipher_check_wrap u0 (
    .clk(clk), .rstN(rstN), .keyWe(keyWe), .keyAddr(keyAddr), .keyData(keyData),
    .checkPeriod(checkPeriod), .inValid(inValid), .inReady(inReady),
    .inDecrypt(inDecrypt), .inData(inData), .outValid(outValid),
    .outReady(outReady), .outData(outData), .busy(busy), .errFlag(errFlag),
    .errClear(errClear)
  );

  function automatic logic [31:0] refEnc(logic [31:0] x);
    logic [31:0] t;
    for (int i = 0; i < 8; i++) begin
      t = x + kb[2*i];
      x = {t[26:0], t[31:27]} ^ kb[2*i+1];
    end
    return x;
  endfunction

  function automatic logic [31:0] refDec(logic [31:0] x);
    logic [31:0] u;
    for (int i = 7; i >= 0; i--) begin
      u = x ^ kb[2*i+1];
      x = {u[4:0], u[31:5]} - kb[2*i];
    end
    return x;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on each edge
  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mBlk = 0; mErr = 0;
    end else begin
      if (errClear) mErr = 0;
      case (mState)
        0: if (inValid) begin
          int per;
          per  = (checkPeriod == 0) ? 1 : int'(checkPeriod);
          mChk = (mBlk == 0);
          mBlk = (mBlk + 1 >= per) ? 0 : mBlk + 1;
          mRes = inDecrypt ? refDec(inData) : refEnc(inData);
          mLen = mChk ? 16 : 8;
          mCnt = 0;
          mState = 1;
        end
        1: begin
          mCnt++;
          if (mCnt == mLen) begin
            if (mChk && mInject) begin mErr = 1; mState = 0; mInject = 0; end
            else mState = 2;
          end
        end
        default: if (outReady) mState = 0;
      endcase
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(inReady == (mState == 0), "R5 inReady", 32'(inReady), 32'(mState == 0));
      chk(busy == (mState != 0), "R5 busy", 32'(busy), 32'(mState != 0));
      chk(outValid == (mState == 2), "R7/R8/R9 outValid timing", 32'(outValid), 32'(mState == 2));
      chk(errFlag == mErr, "R8/R10 errFlag", 32'(errFlag), 32'(mErr));
      if (outValid && mState == 2) begin
        chk(outData == mRes, "R3/R4/R6 outData", outData, mRes);
        lastOut = outData;
      end
    end
  end

  task automatic writeKey(input int a, input logic [31:0] d);
    @(negedge clk);
    keyWe = 1; keyAddr = 4'(a); keyData = d; kb[a] = d;
    @(negedge clk);
    keyWe = 0;
  endtask

  task automatic send(input logic [31:0] d, input bit dec);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1; inData = d; inDecrypt = dec;
    @(negedge clk);
    inValid = 0;
  endtask

  task automatic waitIdle();
    while (!inReady) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) kb[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(inReady == 1, "R1 inReady", 32'(inReady), 1);
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(outValid == 0, "R1 outValid", 32'(outValid), 0);
    chk(errFlag == 0, "R1 errFlag", 32'(errFlag), 0);

    // R2 load distinct round keys
    for (int i = 0; i < 16; i++) writeKey(i, 32'h9E3779B9 * (i + 1) + 32'h0137_F00D);

    // R3 checked encryptions, R6 with a stalled consumer
    checkPeriod = 1;
    send(32'h0000_0000, 0); waitIdle();
    send(32'hDEAD_BEEF, 0); waitIdle();
    outReady = 0;
    send(32'h1234_5678, 0);
    repeat (24) @(negedge clk);
    chk(outValid == 1, "R6 held valid", 32'(outValid), 1);
    outReady = 1;
    waitIdle();

    // R4 round trip: decrypting the last ciphertext returns the plaintext
    send(lastOut, 1); waitIdle();
    chk(lastOut == 32'h1234_5678, "R4 round trip", lastOut, 32'h1234_5678);
    send(32'hFFFF_FFFF, 1); waitIdle();

    // R9 every fourth block checked, mixed directions; R7 latencies via model
    checkPeriod = 4;
    for (int b = 0; b < 6; b++) begin
      send(32'hA5A5_0000 + 32'(b * 77), b[0]);
      waitIdle();
    end
    checkPeriod = 0;
    send(32'h8000_0001, 0); waitIdle();

    // R8 corrupt key word 0 during the check pass of a checked block
    checkPeriod = 1;
    send(32'h0BAD_CAFE, 0);
    repeat (9) @(negedge clk);
    mInject = 1;
    writeKey(0, kb[0] ^ 32'h0000_0100);
    waitIdle();
    chk(errFlag == 1, "R8 mismatch flagged", 32'(errFlag), 1);

    // R10 flag stays through a clean block, then clears
    send(32'h5555_AAAA, 0); waitIdle();
    chk(errFlag == 1, "R10 sticky", 32'(errFlag), 1);
    @(negedge clk); errClear = 1;
    @(negedge clk); errClear = 0;
    chk(errFlag == 0, "R10 cleared", 32'(errFlag), 0);
    send(32'h7777_1111, 1); waitIdle();

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule